// File: doc/BRIEF.md
# Ternary Five-Tuple Flow Filter

This block classifies received IPv4 packets against a table of ternary rules defined over the five-tuple: source address, destination address, protocol, source port and destination port. A parser upstream presents the extracted fields on a lookup interface, one packet per cycle. One registered cycle later the block reports whether any enabled rule matched. The capture formatter uses that result to decide whether a copy of the packet goes to the host. Forwarding to the paired tap port does not depend on this block.

The rule table has 32 entries, arranged as two 16-entry ternary banks. Both banks are searched in parallel and their hits are ORed. The host can rewrite a single entry in one cycle while traffic flows, and each update is atomic. A rule matches in one direction only, so a bidirectional flow needs two entries. When a packet has no port fields, the lookup flags it. Its ports then compare as zero and the key carries a flag bit.

Top module: `flow_filter_top`

## Requirements
- R1: A write (`wr_en`=1) loads entry `wr_idx` with `wr_on`, `wr_value` and `wr_mask` in one cycle. The key layout is bit 104 no-port flag, 103:72 source address, 71:40 destination address, 39:32 protocol, 31:16 source port and 15:0 destination port.
- R2: An enabled entry matches a key when every bit whose mask bit is 1 equals the value bit. Bits whose mask bit is 0 are don't-care.
- R3: An entry written with `wr_on`=0 never matches, whatever its value and mask.
- R4: All 32 entries are searchable. Indices 0..15 form bank 0 and indices 16..31 form bank 1. `res_hit` is the OR of all entry matches.
- R5: Each cycle with `lk_valid`=1 yields `res_valid`=1 on the next cycle, with that lookup's result. Back-to-back lookups are accepted every cycle.
- R6: A lookup in the same cycle as a write sees the entry's old contents. The new contents apply from the next cycle.
- R7: There is no direction swap. A rule for source A to destination B does not match a packet from B to A.
- R8: With `lk_noport`=1 the port inputs are ignored. The key ports are zero and key bit 104 is 1. With `lk_noport`=0, key bit 104 is 0.
- R9: After reset all entries are disabled and `res_valid`=`res_hit`=0.
- R10: `res_hit` is 0 in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_src_ip | input | 32 | Source IPv4 address |
| lk_dst_ip | input | 32 | Destination IPv4 address |
| lk_proto | input | 8 | IP protocol |
| lk_sport | input | 16 | Source port |
| lk_dport | input | 16 | Destination port |
| lk_noport | input | 1 | Packet carries no port fields |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 5 | Rule index |
| wr_on | input | 1 | Rule enable |
| wr_value | input | 105 | Rule value word |
| wr_mask | input | 105 | Rule mask word (1 = compare) |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Some rule matched |

## Verification
A stale or corrupted entry shows up as a wrong `res_hit` on the cycle right after the first lookup whose key that entry governs. The bench therefore writes every index in turn and probes it immediately, both with the exact key and with a neighbouring key. A broken bank decode, or a missing OR of the bank results, would hide one whole half of the index range, and that error would appear within the first sweep. Write-ordering faults appear on the single cycle where a write and a lookup coincide.

// File: rtl/flow_filter_pkg.sv
package flow_filter_pkg;

    localparam int ADDR_W  = 32;
    localparam int PROTO_W = 8;
    localparam int PORT_W  = 16;
    localparam int KEY_W   = 1 + 2*ADDR_W + PROTO_W + 2*PORT_W;

    typedef struct packed {
        logic               noport;
        logic [ADDR_W-1:0]  src_ip;
        logic [ADDR_W-1:0]  dst_ip;
        logic [PROTO_W-1:0] proto;
        logic [PORT_W-1:0]  sport;
        logic [PORT_W-1:0]  dport;
    } flow_key_t;

    typedef struct packed {
        logic      on;
        flow_key_t value;
        flow_key_t mask;
    } rule_t;

    function automatic logic rule_hits(rule_t r, flow_key_t k);
        return r.on && (((r.value ^ k) & r.mask) == '0);
    endfunction

endpackage

// File: rtl/flow_filter_entry.sv
module flow_filter_entry
    import flow_filter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_sel,
    input  rule_t     wr_rule,
    input  flow_key_t key,
    output logic      hit
);

    rule_t rule_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rule_q <= '0;
        end else if (wr_sel) begin
            rule_q <= wr_rule;
        end
    end

    assign hit = rule_hits(rule_q, key);

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> (rule_q == $past(wr_rule)));

    assert_off_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wr_rule.on) |=> !hit);

endmodule

// File: rtl/flow_filter_bank.sv
module flow_filter_bank
    import flow_filter_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LOC_W = $clog2(DEPTH)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LOC_W-1:0] wr_loc,
    input  rule_t            wr_rule,
    input  flow_key_t        key,
    output logic             bank_hit
);

    logic [DEPTH-1:0] sel;
    logic [DEPTH-1:0] hits;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign sel[e] = wr_en && (wr_loc == LOC_W'(e));
        flow_filter_entry u_entry (
            .clk     (clk),
            .rst     (rst),
            .wr_sel  (sel[e]),
            .wr_rule (wr_rule),
            .key     (key),
            .hit     (hits[e])
        );
    end

    assign bank_hit = |hits;

    assert_single_write_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/flow_filter_top.sv
module flow_filter_top
    import flow_filter_pkg::*;
#(
    parameter int BANKS = 2,
    parameter int DEPTH = 16,
    localparam int RULES = BANKS * DEPTH,
    localparam int IDX_W = $clog2(RULES),
    localparam int LOC_W = $clog2(DEPTH)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_src_ip,
    input  logic [ADDR_W-1:0]  lk_dst_ip,
    input  logic [PROTO_W-1:0] lk_proto,
    input  logic [PORT_W-1:0]  lk_sport,
    input  logic [PORT_W-1:0]  lk_dport,
    input  logic               lk_noport,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_on,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_mask,
    output logic               res_valid,
    output logic               res_hit
);

    flow_key_t        key;
    rule_t            wr_rule;
    logic [BANKS-1:0] bank_hits;
    logic [LOC_W-1:0] wr_loc;

    always_comb begin
        key.noport = lk_noport;
        key.src_ip = lk_src_ip;
        key.dst_ip = lk_dst_ip;
        key.proto  = lk_proto;
        key.sport  = lk_noport ? '0 : lk_sport;
        key.dport  = lk_noport ? '0 : lk_dport;
    end

    assign wr_rule = '{on: wr_on, value: flow_key_t'(wr_value), mask: flow_key_t'(wr_mask)};
    assign wr_loc  = wr_idx[LOC_W-1:0];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en && ((wr_idx >> LOC_W) == IDX_W'(b));
        flow_filter_bank #(.DEPTH(DEPTH)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_wr),
            .wr_loc   (wr_loc),
            .wr_rule  (wr_rule),
            .key      (key),
            .bank_hit (bank_hits[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && (|bank_hits);
        end
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_hit);

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit));

endmodule

// File: tb/tb_flow_filter_top.sv
module tb_flow_filter_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_src_ip = '0, lk_dst_ip = '0;
    logic [7:0]   lk_proto = '0;
    logic [15:0]  lk_sport = '0, lk_dport = '0;
    logic         lk_noport = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic         wr_on = 1'b0;
    logic [104:0] wr_value = '0, wr_mask = '0;
    logic         res_valid, res_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic         m_on  [32];
    logic [104:0] m_val [32];
    logic [104:0] m_msk [32];

    always #2 clk = ~clk;

    flow_filter_top dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid),
        .lk_src_ip(lk_src_ip), .lk_dst_ip(lk_dst_ip), .lk_proto(lk_proto),
        .lk_sport(lk_sport), .lk_dport(lk_dport), .lk_noport(lk_noport),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_on(wr_on),
        .wr_value(wr_value), .wr_mask(wr_mask),
        .res_valid(res_valid), .res_hit(res_hit)
    );

    function automatic logic [104:0] mk(logic np, logic [31:0] s, logic [31:0] d,
                                        logic [7:0] p, logic [15:0] sp, logic [15:0] dp);
        return {np, s, d, p, np ? 16'h0 : sp, np ? 16'h0 : dp};
    endfunction

    function automatic logic expect_hit(logic [104:0] k);
        logic h = 1'b0;
        for (int i = 0; i < 32; i++)
            if (m_on[i] && (((m_val[i] ^ k) & m_msk[i]) == '0)) h = 1'b1;
        return h;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic drive_key(logic [31:0] s, logic [31:0] d, logic [7:0] p,
                             logic [15:0] sp, logic [15:0] dp, logic np);
        lk_valid = 1'b1; lk_src_ip = s; lk_dst_ip = d; lk_proto = p;
        lk_sport = sp; lk_dport = dp; lk_noport = np;
    endtask

    task automatic lookup(string req, logic [31:0] s, logic [31:0] d, logic [7:0] p,
                          logic [15:0] sp, logic [15:0] dp, logic np);
        logic exp;
        @(negedge clk);
        drive_key(s, d, p, sp, dp, np);
        exp = expect_hit(mk(np, s, d, p, sp, dp));
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, res_valid, 1'b1);
        check({req, " hit"}, res_hit, exp);
    endtask

    task automatic write_rule(int idx, logic on, logic [104:0] v, logic [104:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_on = on; wr_value = v; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0;
        m_on[idx] = on; m_val[idx] = v; m_msk[idx] = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_on[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", res_valid, 1'b0);
        check("R9 reset hit", res_hit, 1'b0);
        rst = 1'b0;
        // R9: all entries disabled, so an all-zero key misses
        lookup("R9 empty table", 32'h0, 32'h0, 8'h0, 16'h0, 16'h0, 1'b0);
        @(negedge clk);
        check("R10 idle hit", res_hit, 1'b0);
        check("R5 idle valid", res_valid, 1'b0);

        // R1 R4 R3: sweep every index across both banks
        for (int i = 0; i < 32; i++) begin
            logic [31:0] s = 32'h0A000000 + i;
            logic [31:0] d = 32'hC0A80100 + 3*i;
            write_rule(i, 1'b1, mk(1'b0, s, d, 8'd17, 16'(1000+i), 16'd53), {105{1'b1}});
            lookup("R4 R1 exact", s, d, 8'd17, 16'(1000+i), 16'd53, 1'b0);
            lookup("R2 neighbour miss", s, d, 8'd17, 16'(1001+i), 16'd53, 1'b0);
            write_rule(i, 1'b0, mk(1'b0, s, d, 8'd17, 16'(1000+i), 16'd53), 105'h0);
            lookup("R3 disabled", s, d, 8'd17, 16'(1000+i), 16'd53, 1'b0);
        end

        // R2: mask only on protocol field at entry 20 (bank 1)
        write_rule(20, 1'b1, mk(1'b0, 0, 0, 8'd6, 0, 0), {1'b0, 64'h0, 8'hFF, 32'h0});
        for (int p = 0; p < 256; p++)
            lookup("R2 proto ternary", 32'h01020300 + p, 32'hFEDC0000 ^ p, 8'(p),
                   16'(p*7), 16'(p*13), 1'b0);
        write_rule(20, 1'b0, '0, '0);

        // R7: one-direction rule at entry 3
        write_rule(3, 1'b1, mk(1'b0, 32'h0A0A0A01, 32'h0A0A0A02, 8'd6, 16'd4000, 16'd80),
                   {105{1'b1}});
        lookup("R7 forward", 32'h0A0A0A01, 32'h0A0A0A02, 8'd6, 16'd4000, 16'd80, 1'b0);
        lookup("R7 reverse", 32'h0A0A0A02, 32'h0A0A0A01, 8'd6, 16'd80, 16'd4000, 1'b0);
        check("R7 reverse model", expect_hit(mk(1'b0, 32'h0A0A0A02, 32'h0A0A0A01, 8'd6,
              16'd80, 16'd4000)), 1'b0);

        // R8: no-port rule at entry 9
        write_rule(9, 1'b1, mk(1'b1, 32'h0B000001, 32'h0B000002, 8'd1, 0, 0), {105{1'b1}});
        lookup("R8 noport hit", 32'h0B000001, 32'h0B000002, 8'd1, 16'hBEEF, 16'h1234, 1'b1);
        lookup("R8 flag clear miss", 32'h0B000001, 32'h0B000002, 8'd1, 16'h0, 16'h0, 1'b0);

        // R6: write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd27; wr_on = 1'b1;
        wr_value = mk(1'b0, 32'h0C000001, 32'h0C000002, 8'd17, 16'd7, 16'd8);
        wr_mask = {105{1'b1}};
        drive_key(32'h0C000001, 32'h0C000002, 8'd17, 16'd7, 16'd8, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        m_on[27] = 1'b1; m_val[27] = wr_value; m_msk[27] = wr_mask;
        // R5: back-to-back, this cycle's lookup sees the new contents
        check("R6 same-cycle valid", res_valid, 1'b1);
        check("R6 same-cycle old", res_hit, 1'b0);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R5 back-to-back valid", res_valid, 1'b1);
        check("R6 next-cycle new", res_hit, 1'b1);
        @(negedge clk);
        check("R10 after burst", res_hit, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule